// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block drives the command cycles that erase part or all of a parallel NOR flash device, and then watches the device's status until the erase has finished or failed. A requester picks one of three command families, an erase scope and a target address, and pulses `start`. The sequencer emits the family's write cycles on a simple bus master port, polls the status byte, and reports the result with a one-cycle `done` pulse and an `error` level.

The first family, called "standard" here, uses a six-write command preamble in which only the last write depends on the erase scope. The second, "alternate", uses the same preamble and the same scope codes but treats status bit 5 as meaningless. The third, "block-locked", works block by block: it can unlock the target block first, and it clears its status register and returns to read mode at the end. If a family cannot perform the requested scope, the sequencer silently performs a sector erase. A bounded poll count turns a device that never finishes into an error.

Each bus write lasts one cycle with `bus_we` high. Each status read lasts one cycle with `bus_re` high, and `bus_rdata` is sampled on the clock edge that ends that cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: A `start` pulse is accepted only while the block is idle, and `busy` is high in the cycle that follows it. While an erase is running, `start` and all request inputs are ignored, and the running sequence continues unchanged.
- R2: `family` encoding: 0 is standard, 1 is block-locked, 2 is alternate, and 3 is treated as standard. For the standard and alternate families the first five writes are, in order: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555 and 0x55 to 0x2AA. For these families `unlock` has no effect.
- R3: `mode` encoding: 0 is sector, 1 is block, 2 is chip, and 3 is treated as sector. The sixth write carries 0x30 to the target address for a sector erase, 0x50 to the target address for a block erase, and 0x10 to address 0x555 for a chip erase.
- R4: Chip erase is honoured by the standard and alternate families only, and block erase by the alternate family only. Any other request falls back to a sector erase. For the block-locked family, every scope issues that family's single block erase command.
- R5: The block-locked family writes, all to the target address: 0x60 then 0xD0 (only when `unlock` is high), then 0x20 and 0xD0, then the status polls, then 0x50 and 0xFF. The last two writes are issued whether the erase passed or failed.
- R6: Standard and alternate polling ends successfully when status bit 7 reads 1, or when bit 6 has the same value on two consecutive reads.
- R7: For the standard family, a read that is still busy (bit 7 is 0 and bit 6 is still toggling) with bit 5 set ends the erase with an error. The alternate family ignores bit 5.
- R8: Block-locked polling ends when status bit 7 reads 1. The erase fails if bit 5 or bit 3 is set in that read.
- R9: If `MAX_POLLS` consecutive status reads are all still busy, polling stops after that many reads and the erase ends with an error.
- R10: After reset the block is idle, with `busy`, `done`, `error`, `bus_we` and `bus_re` all low. `done` is a single-cycle pulse. `error` is valid with `done` and holds until the next accepted `start`. `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted when idle |
| family | input | 2 | Command family (R2 encoding) |
| mode | input | 2 | Requested erase scope (R3 encoding) |
| unlock | input | 1 | Unlock the target block first (block-locked family only) |
| target_addr | input | AW | Sector or block address to erase |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result of the last erase; 1 means failed |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data; the command is in bits 7:0 |
| bus_we | output | 1 | Write strobe, one cycle per write |
| bus_re | output | 1 | Read strobe, one cycle per status read |
| bus_rdata | input | 8 | Status byte, sampled at the end of a read cycle |

## Verification
The bench models the flash status byte in three ways. A word that toggles bit 6 and then settles to all ones separates completion on bit 7 from completion on a settled toggle bit. A word that settles to zero makes completion depend on bit 6 alone. A word that never settles exercises the poll limit. Injecting bit 5 into the busy word makes the standard family fail while the alternate family runs to completion. Final status words carrying bit 5 or bit 3 separate the block-locked family's two failure causes from its clean finish. Every family and scope combination is checked on the exact command writes it produces, which exposes any fallback mistake. A second `start` pulse during a running erase shows that a busy request is dropped.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [1:0] {
        FAM_STD    = 2'd0,
        FAM_LOCKED = 2'd1,
        FAM_ALT    = 2'd2,
        FAM_RSVD   = 2'd3
    } fam_e;

    typedef enum logic [1:0] {
        EM_SECTOR = 2'd0,
        EM_BLOCK  = 2'd1,
        EM_CHIP   = 2'd2,
        EM_RSVD   = 2'd3
    } emode_e;

    typedef enum logic [1:0] {
        OP_WR   = 2'd0,
        OP_POLL = 2'd1,
        OP_END  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        PR_BUSY = 2'd0,
        PR_OK   = 2'd1,
        PR_FAIL = 2'd2
    } pres_e;

    typedef struct packed {
        op_e         op;
        logic        at_target;
        logic [11:0] caddr;
        logic [7:0]  cdata;
    } step_t;

    localparam logic [11:0] ADR_KEY_A = 12'h555;
    localparam logic [11:0] ADR_KEY_B = 12'h2AA;

    localparam logic [7:0] CMD_KEY_A     = 8'hAA;
    localparam logic [7:0] CMD_KEY_B     = 8'h55;
    localparam logic [7:0] CMD_ARM       = 8'h80;
    localparam logic [7:0] CMD_EZ_CHIP   = 8'h10;
    localparam logic [7:0] CMD_EZ_SECTOR = 8'h30;
    localparam logic [7:0] CMD_EZ_BLOCK  = 8'h50;
    localparam logic [7:0] CMD_LK_OPEN   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_LK_ERASE  = 8'h20;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_READ_ARR  = 8'hFF;

    function automatic fam_e norm_family(logic [1:0] raw);
        fam_e f;
        f = fam_e'(raw);
        if (f == FAM_RSVD) f = FAM_STD;
        return f;
    endfunction

    function automatic emode_e resolve_mode(fam_e f, logic [1:0] raw);
        emode_e m;
        case (raw)
            2'd2:    m = (f != FAM_LOCKED) ? EM_CHIP : EM_SECTOR;
            2'd1:    m = (f == FAM_ALT) ? EM_BLOCK : EM_SECTOR;
            default: m = EM_SECTOR;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] scope_code(emode_e m);
        logic [7:0] c;
        case (m)
            EM_CHIP:  c = CMD_EZ_CHIP;
            EM_BLOCK: c = CMD_EZ_BLOCK;
            default:  c = CMD_EZ_SECTOR;
        endcase
        return c;
    endfunction

    function automatic step_t step_of(fam_e f, emode_e m, logic [2:0] idx);
        step_t s;
        s.op        = OP_WR;
        s.at_target = 1'b1;
        s.caddr     = '0;
        s.cdata     = '0;
        if (f == FAM_LOCKED) begin
            case (idx)
                3'd0: s.cdata = CMD_LK_OPEN;
                3'd1: s.cdata = CMD_CONFIRM;
                3'd2: s.cdata = CMD_LK_ERASE;
                3'd3: s.cdata = CMD_CONFIRM;
                3'd4: s.op    = OP_POLL;
                3'd5: s.cdata = CMD_CLR_STAT;
                3'd6: s.cdata = CMD_READ_ARR;
                default: s.op = OP_END;
            endcase
        end else begin
            case (idx)
                3'd0: begin s.at_target = 1'b0; s.caddr = ADR_KEY_A; s.cdata = CMD_KEY_A; end
                3'd1: begin s.at_target = 1'b0; s.caddr = ADR_KEY_B; s.cdata = CMD_KEY_B; end
                3'd2: begin s.at_target = 1'b0; s.caddr = ADR_KEY_A; s.cdata = CMD_ARM;   end
                3'd3: begin s.at_target = 1'b0; s.caddr = ADR_KEY_A; s.cdata = CMD_KEY_A; end
                3'd4: begin s.at_target = 1'b0; s.caddr = ADR_KEY_B; s.cdata = CMD_KEY_B; end
                3'd5: begin
                    s.at_target = (m != EM_CHIP);
                    s.caddr     = ADR_KEY_A;
                    s.cdata     = scope_code(m);
                end
                3'd6: s.op = OP_POLL;
                default: s.op = OP_END;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/fes_step_table.sv
module fes_step_table
    import fes_pkg::*;
(
    input  fam_e       fam,
    input  emode_e     mode,
    input  logic [2:0] idx,
    output step_t      step
);
    always_comb step = step_of(fam, mode, idx);
endmodule

// File: rtl/fes_status_eval.sv
module fes_status_eval
    import fes_pkg::*;
(
    input  fam_e       fam,
    input  logic [7:0] stat,
    input  logic       prev_q6,
    input  logic       first,
    output pres_e      result
);
    logic settled;

    always_comb begin
        settled = !first && (stat[6] == prev_q6);
        result  = PR_BUSY;
        if (fam == FAM_LOCKED) begin
            if (stat[7]) result = (stat[5] || stat[3]) ? PR_FAIL : PR_OK;
        end else begin
            if (stat[7] || settled)                result = PR_OK;
            else if (fam != FAM_ALT && stat[5])    result = PR_FAIL;
        end
    end
endmodule

// File: rtl/fes_poll_timer.sv
module fes_poll_timer #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LIM = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)          cnt_q <= '0;
        else if (tick && !expired) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIM);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 16,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    family,
    input  logic [1:0]    mode,
    input  logic          unlock,
    input  logic [AW-1:0] target_addr,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    input  logic [7:0]    bus_rdata
);
    typedef enum logic {S_IDLE, S_RUN} st_e;

    st_e           st_q;
    logic [2:0]    idx_q;
    fam_e          fam_q;
    emode_e        mode_q;
    logic [AW-1:0] tgt_q;
    logic          err_q, prev6_q, first_q;

    step_t         cur;
    pres_e         pr;
    fam_e          req_fam;
    logic          accept, in_poll, tick, expired, poll_end;
    logic [AW-1:0] ca_ext;
    logic [7:0]    wr_byte;

    fes_step_table u_tab (
        .fam  (fam_q),
        .mode (mode_q),
        .idx  (idx_q),
        .step (cur)
    );

    fes_status_eval u_eval (
        .fam     (fam_q),
        .stat    (bus_rdata),
        .prev_q6 (prev6_q),
        .first   (first_q),
        .result  (pr)
    );

    fes_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .tick    (tick),
        .expired (expired)
    );

    assign req_fam  = norm_family(family);
    assign accept   = (st_q == S_IDLE) && start;
    assign in_poll  = (st_q == S_RUN) && (cur.op == OP_POLL);
    assign tick     = in_poll && (pr == PR_BUSY);
    assign poll_end = in_poll && ((pr != PR_BUSY) || expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            idx_q   <= '0;
            fam_q   <= FAM_STD;
            mode_q  <= EM_SECTOR;
            tgt_q   <= '0;
            err_q   <= 1'b0;
            prev6_q <= 1'b0;
            first_q <= 1'b1;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        fam_q   <= req_fam;
                        mode_q  <= resolve_mode(req_fam, mode);
                        tgt_q   <= target_addr;
                        err_q   <= 1'b0;
                        first_q <= 1'b1;
                        idx_q   <= (req_fam == FAM_LOCKED && !unlock) ? 3'd2 : 3'd0;
                        st_q    <= S_RUN;
                    end
                end
                default: begin
                    case (cur.op)
                        OP_WR: idx_q <= idx_q + 3'd1;
                        OP_POLL: begin
                            if (poll_end) begin
                                err_q <= (pr != PR_OK);
                                idx_q <= idx_q + 3'd1;
                            end else begin
                                prev6_q <= bus_rdata[6];
                                first_q <= 1'b0;
                            end
                        end
                        default: st_q <= S_IDLE;
                    endcase
                end
            endcase
        end
    end

    always_comb begin
        ca_ext        = '0;
        ca_ext[11:0]  = cur.caddr;
    end

    assign busy    = (st_q == S_RUN) && (cur.op != OP_END);
    assign done    = (st_q == S_RUN) && (cur.op == OP_END);
    assign error   = err_q;
    assign bus_we  = (st_q == S_RUN) && (cur.op == OP_WR);
    assign bus_re  = in_poll;
    assign bus_addr = (st_q != S_RUN)                       ? '0 :
                      (cur.at_target || cur.op == OP_POLL)  ? tgt_q : ca_ext;
    assign wr_byte = bus_we ? cur.cdata : 8'h00;

    generate
        if (DW > 8) begin : g_wide
            assign bus_wdata = {{(DW-8){1'b0}}, wr_byte};
        end else begin : g_narrow
            assign bus_wdata = wr_byte;
        end
    endgenerate

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_start_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && start) |=> busy);
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_RUN) |=> ($stable(fam_q) && $stable(tgt_q) && $stable(mode_q)));
    p_no_chip_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_wdata[7:0] == CMD_EZ_CHIP) |-> (fam_q != FAM_LOCKED));
    p_no_block_std_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_wdata[7:0] == CMD_EZ_BLOCK) |-> (fam_q != FAM_STD));
    p_alt_no_fail_r7: assert property (@(posedge clk) disable iff (rst)
        (in_poll && fam_q == FAM_ALT) |-> (pr != PR_FAIL));
    p_error_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && !start) |=> $stable(err_q));
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int MAXP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    family = 2'd0;
    logic [1:0]    mode = 2'd0;
    logic          unlock = 1'b0;
    logic [AW-1:0] target_addr = '0;
    logic          busy, done, error;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we, bus_re;
    logic [7:0]    bus_rdata;

    always #5 clk = ~clk;

    flash_erase_seq #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst(rst), .start(start), .family(family), .mode(mode),
        .unlock(unlock), .target_addr(target_addr), .busy(busy), .done(done),
        .error(error), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
    } wr_t;

    wr_t exp_q[$];
    int  n_run = 0;
    int  n_fail = 0;

    // flash status model
    int         rd_cnt = 0;
    int         base = 0;
    logic       m_locked = 1'b0;
    int         m_busy_n = 0;
    logic [7:0] m_final = 8'hFF;
    logic       m_b5 = 1'b0;

    always @(posedge clk) if (bus_re) rd_cnt <= rd_cnt + 1;

    always @* begin
        int k;
        k = rd_cnt - base;
        if (k < m_busy_n)
            bus_rdata = m_locked ? 8'h00 : {1'b0, k[0], m_b5, 5'b0};
        else
            bus_rdata = m_final;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected writes as the design issues them
    always @(negedge clk) begin
        if (!rst && bus_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected write data", int'(bus_wdata), 0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check(bus_addr == e.a, e.tag, "write address", int'(bus_addr), int'(e.a));
                check(bus_wdata == e.d, e.tag, "write data", int'(bus_wdata), int'(e.d));
            end
        end
    end

    task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        wr_t e;
        e.a = a; e.d = {{(DW-8){1'b0}}, d}; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run_op(input logic [1:0] fam, input logic [1:0] md, input logic unl,
                          input logic [AW-1:0] tgt, input int bn, input logic [7:0] fin,
                          input logic b5, input logic exp_err, input int exp_reads,
                          input string tag, input bit poke);
        int cnt;
        bit locked;
        locked = (fam == 2'd1);
        if (locked) begin
            if (unl) begin
                push_wr(tgt, 8'h60, "R5");
                push_wr(tgt, 8'hD0, "R5");
            end
            push_wr(tgt, 8'h20, "R4");
            push_wr(tgt, 8'hD0, "R5");
            push_wr(tgt, 8'h50, "R5");
            push_wr(tgt, 8'hFF, "R5");
        end else begin
            push_wr(24'h555, 8'hAA, "R2");
            push_wr(24'h2AA, 8'h55, "R2");
            push_wr(24'h555, 8'h80, "R2");
            push_wr(24'h555, 8'hAA, "R2");
            push_wr(24'h2AA, 8'h55, "R2");
            if (md == 2'd2)                     push_wr(24'h555, 8'h10, "R3");
            else if (md == 2'd1 && fam == 2'd2) push_wr(tgt, 8'h50, "R3");
            else                                push_wr(tgt, 8'h30, "R4");
        end
        m_locked = locked;
        base     = rd_cnt;
        m_busy_n = bn;
        m_final  = fin;
        m_b5     = b5;
        @(negedge clk);
        family = fam; mode = md; unlock = unl; target_addr = tgt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1", {tag, " busy after start"}, busy, 1);
        check(error == 1'b0, "R10", {tag, " error cleared by start"}, error, 0);
        if (poke) begin
            family = 2'd1; mode = 2'd2; unlock = 1'b1; target_addr = 24'h00FF00; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R1", {tag, " busy while running"}, busy, 1);
        end
        cnt = 0;
        while (!done && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        check(done == 1'b1, tag, "done seen", done, 1);
        check(error == exp_err, tag, "error result", error, exp_err);
        check((rd_cnt - base) == exp_reads, tag, "status read count", rd_cnt - base, exp_reads);
        @(negedge clk);
        check(done == 1'b0, "R10", {tag, " done is one cycle"}, done, 0);
        check(error == exp_err, "R10", {tag, " error held"}, error, exp_err);
        check(exp_q.size() == 0, tag, "writes outstanding", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(100000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !error, "R10", "reset outputs", {busy, done, error}, 0);
        check(!bus_we && !bus_re, "R10", "reset strobes", {bus_we, bus_re}, 0);

        // R2 R3: standard sector, ends on bit 7 after 3 busy reads
        run_op(2'd0, 2'd0, 1'b0, 24'h012000, 3, 8'hFF, 1'b0, 1'b0, 4, "R3", 1'b0);
        // R3: standard chip
        run_op(2'd0, 2'd2, 1'b0, 24'h034000, 0, 8'hFF, 1'b0, 1'b0, 1, "R3", 1'b0);
        // R4: standard block falls back to sector; unlock ignored (R2)
        run_op(2'd0, 2'd1, 1'b1, 24'h056000, 1, 8'hFF, 1'b0, 1'b0, 2, "R4", 1'b0);
        // R3: alternate block
        run_op(2'd2, 2'd1, 1'b0, 24'h078000, 2, 8'hFF, 1'b0, 1'b0, 3, "R3", 1'b0);
        // R3: alternate chip
        run_op(2'd2, 2'd2, 1'b0, 24'h010000, 0, 8'hFF, 1'b0, 1'b0, 1, "R3", 1'b0);
        // R2: family code 3 behaves as standard
        run_op(2'd3, 2'd2, 1'b0, 24'h020000, 0, 8'hFF, 1'b0, 1'b0, 1, "R2", 1'b0);
        // R4: mode code 3 is sector
        run_op(2'd0, 2'd3, 1'b0, 24'h0A0000, 0, 8'hFF, 1'b0, 1'b0, 1, "R4", 1'b0);
        // R5 R8: block-locked with unlock, chip request falls back
        run_op(2'd1, 2'd2, 1'b1, 24'h0C0000, 3, 8'h80, 1'b0, 1'b0, 4, "R8", 1'b0);
        // R8: block-locked bit 5 failure
        run_op(2'd1, 2'd0, 1'b0, 24'h0D0000, 0, 8'hA0, 1'b0, 1'b1, 1, "R8", 1'b0);
        // R8: block-locked bit 3 failure
        run_op(2'd1, 2'd1, 1'b0, 24'h0E0000, 1, 8'h88, 1'b0, 1'b1, 2, "R8", 1'b0);
        // R7: standard fails on bit 5 while busy
        run_op(2'd0, 2'd0, 1'b0, 24'h100000, 5, 8'hFF, 1'b1, 1'b1, 1, "R7", 1'b0);
        // R7: alternate ignores bit 5
        run_op(2'd2, 2'd0, 1'b0, 24'h110000, 5, 8'hFF, 1'b1, 1'b0, 6, "R7", 1'b0);
        // R6: completion by settled toggle bit
        run_op(2'd0, 2'd0, 1'b0, 24'h120000, 4, 8'h00, 1'b0, 1'b0, 6, "R6", 1'b0);
        // R9: poll limit
        run_op(2'd0, 2'd0, 1'b0, 24'h130000, 100000, 8'hFF, 1'b0, 1'b1, MAXP, "R9", 1'b0);
        repeat (3) @(negedge clk);
        check(error == 1'b1, "R10", "error held while idle", error, 1);
        // R1: start during run ignored; next start clears error (R10)
        run_op(2'd0, 2'd0, 1'b0, 24'h140000, 2, 8'hFF, 1'b0, 1'b0, 3, "R1", 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule